// File: doc/BRIEF.md
# Paged Quad Write Sequencer

This block is the host side of a quad serial link. It writes a long byte stream to a NOR-style serial device, or to a display controller that accepts the same framing. Software-facing logic supplies a start address, a byte count from 1 to 65535, a write opcode and three mode bits with a one-cycle start pulse. The bytes themselves then arrive over a valid/ready stream. The block produces the serial clock, the active-low chip select and four IO lines, each with its own output enable.

In paged mode the buffer is cut into page-sized program transactions. Before each page the block sends a write-enable command. After each page it polls the status register until the write-in-progress bit clears. Each following page goes to an address one page size higher than the last. With pagination disabled, the block sends one opcode and one address and then streams the entire count in a single chip-select-low transaction. This suits targets that treat a changed address as a new command.

Top module: `qspi_page_writer`

## Requirements
- R1: In paged mode the stream is split into program transactions of 256 bytes (page_big_i=0) or 512 bytes (page_big_i=1). The last transaction carries only the bytes that remain. Each program transaction sends the opcode, then the address, then its data bytes, all with cs_no held low.
- R2: After every program transaction in paged mode, a status read is sent. It consists of opcode 0x05 followed by 8 more SCK cycles that sample io_i[1]. The status read is repeated, each time as its own transaction, for as long as the sampled bit 0 (the last bit received) is 1.
- R3: In paged mode a write-enable transaction (opcode 0x06 alone) precedes the first page. Once the status shows not busy, another write-enable is sent only if bytes remain.
- R4: Each page after the first is addressed at the previous page's address plus the page size. For example, 0x003C00 is followed by 0x003E00 for 512-byte pages.
- R5: The program opcode is the value of wr_op_i captured when start is accepted, for example 0x32 or 0xDE.
- R6: Opcode and address go out on IO0 only (io_oe_o=0001), MSB first, one bit per SCK rising edge. SCK idles low. Each SCK high lasts one clock and each low at least one clock. The address is the low 3 bytes when addr32_i=0 and all 4 bytes when addr32_i=1.
- R7: Data bytes go out on IO3..IO0 with io_oe_o=1111, 4 bits per SCK rising edge. The high nibble goes first, and IO3 carries the nibble's MSB.
- R8: When no_page_i=1, the whole transfer is one transaction made of opcode, address and every data byte. No write-enable or status read is sent.
- R9: Between transactions cs_no stays high for at least 2 clocks. While cs_no is high, sck_o is low and io_oe_o is 0000.
- R10: busy_o rises the cycle after a start is accepted. After the final transaction, done_o pulses for one cycle with cs_no high, and busy_o is low on the next cycle.
- R11: start_i is ignored while busy_o is high, and it is ignored when len_i is 0.
- R12: wr_ready_o is high only during a data phase, while no byte is held. While it is high, sck_o stays low, so the serial clock stalls when the stream runs dry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | 32 | Start address |
| len_i | input | LEN_W | Byte count |
| wr_op_i | input | 8 | Program opcode |
| addr32_i | input | 1 | 1: four address bytes, 0: three |
| page_big_i | input | 1 | 1: 512-byte pages, 0: 256-byte pages |
| no_page_i | input | 1 | 1: single transaction, no paging |
| wr_data_i | input | 8 | Stream byte |
| wr_valid_i | input | 1 | Stream byte valid |
| wr_ready_o | output | 1 | Stream byte accepted when valid is also high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | IO line output values |
| io_oe_o | output | 4 | IO line output enables |
| io_i | input | 4 | IO line input values (bit 1 carries status) |

## Verification
The assertions check on every cycle the line-level rules: the bus is quiet while chip select is high, the minimum deselect time, the width of each SCK high, the allowed output-enable codes, the ready window with SCK held low, the done/busy handover, and that a zero-length start is dropped. Only the bench scenarios can show the transaction content. That covers page splitting and the short last page, the address step, the opcode and address widths, nibble order, repeated status polling against a device model, write-enable placement, the unpaged single transaction, and a start pulse ignored in mid-transfer while the stream stalls.

// File: rtl/qspi_pw_pkg.sv
package qspi_pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_WREN,
    ST_HDR,
    ST_DATA,
    ST_RDSR,
    ST_DONE
  } st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam int HDR_W = 40;
  localparam int HCNT_W = 6;
endpackage

// File: rtl/qspi_pw_cmd_shift.sv
// Single-line command shifter: MSB first on IO0, samples IO1 each high phase.
module qspi_pw_cmd_shift #(
  parameter int VEC_W = 40,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             fin_o,
  output logic [7:0]       status_o
);
  logic [VEC_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, ph_q;
  logic [7:0]       rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      ph_q  <= 1'b0;
      rx_q  <= '0;
    end else if (load_i) begin
      sr_q  <= vec_i;
      cnt_q <= nbits_i;
      act_q <= 1'b1;
      ph_q  <= 1'b0;
    end else if (act_q) begin
      if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        ph_q <= 1'b0;
        rx_q <= {rx_q[6:0], miso_i};
        if (cnt_q == CNT_W'(1)) begin
          act_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          sr_q  <= sr_q << 1;
        end
      end
    end
  end

  assign sck_o    = act_q & ph_q;
  assign mosi_o   = sr_q[VEC_W-1];
  assign fin_o    = act_q & ph_q & (cnt_q == CNT_W'(1));
  assign status_o = {rx_q[6:0], miso_i};
endmodule

// File: rtl/qspi_pw_quad_tx.sv
// Quad data phase: one byte per handshake, high nibble first.
module qspi_pw_quad_tx #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] count_i,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             sck_o,
  output logic [3:0]       nib_o,
  output logic             fin_o
);
  logic             act_q, need_q, ph_q, lo_q;
  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      need_q <= 1'b0;
      ph_q   <= 1'b0;
      lo_q   <= 1'b0;
      cnt_q  <= '0;
      byte_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      need_q <= 1'b1;
      ph_q   <= 1'b0;
      lo_q   <= 1'b0;
      cnt_q  <= count_i;
    end else if (act_q) begin
      if (need_q) begin
        if (valid_i) begin
          byte_q <= byte_i;
          need_q <= 1'b0;
          ph_q   <= 1'b0;
          lo_q   <= 1'b0;
        end
      end else if (!ph_q) begin
        ph_q <= 1'b1;
      end else begin
        ph_q <= 1'b0;
        if (!lo_q) begin
          lo_q <= 1'b1;
        end else if (cnt_q == LEN_W'(1)) begin
          act_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_q - LEN_W'(1);
          need_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o = act_q & need_q;
  assign sck_o   = act_q & ~need_q & ph_q;
  assign nib_o   = lo_q ? byte_q[3:0] : byte_q[7:4];
  assign fin_o   = act_q & ~need_q & ph_q & lo_q & (cnt_q == LEN_W'(1));
endmodule

// File: rtl/qspi_pw_page_track.sv
// Holds the running address and the bytes left; sizes the next chunk.
module qspi_pw_page_track #(
  parameter int LEN_W  = 16,
  parameter int PG_LG2 = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             big_i,
  input  logic             nopage_i,
  input  logic             adv_i,
  output logic [31:0]      addr_o,
  output logic [LEN_W-1:0] chunk_o,
  output logic             empty_o
);
  localparam logic [31:0] PG_SMALL = 32'(1) << PG_LG2;
  localparam logic [31:0] PG_LARGE = 32'(1) << (PG_LG2 + 1);

  logic [31:0]      addr_q;
  logic [LEN_W-1:0] remain_q;
  logic [31:0]      page_sz, rem32, chunk32;

  assign page_sz = big_i ? PG_LARGE : PG_SMALL;
  assign rem32   = 32'(remain_q);
  assign chunk32 = (nopage_i || rem32 < page_sz) ? rem32 : page_sz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      addr_q   <= addr_i;
      remain_q <= len_i;
    end else if (adv_i) begin
      addr_q   <= addr_q + page_sz;
      remain_q <= remain_q - chunk_o;
    end
  end

  assign addr_o  = addr_q;
  assign chunk_o = LEN_W'(chunk32);
  assign empty_o = (remain_q == '0);
endmodule

// File: rtl/qspi_page_writer.sv
module qspi_page_writer
  import qspi_pw_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int PG_LG2  = 8,
  parameter int GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       wr_op_i,
  input  logic             addr32_i,
  input  logic             page_big_i,
  input  logic             no_page_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);
  localparam int GC_W = $clog2(GAP_CYC + 1);

  st_e              st_q, nxt_q;
  logic [GC_W-1:0]  gap_q;
  logic [7:0]       op_q;
  logic             a32_q, big_q, nop_q;

  logic             accept, gap_done;
  logic             sh_load, sh_sck, sh_mosi, sh_fin;
  logic [HDR_W-1:0] sh_vec;
  logic [HCNT_W-1:0] sh_nbits;
  logic [7:0]       sh_status;
  logic             q_start, q_sck, q_fin;
  logic [3:0]       q_nib;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] chunk;
  logic             trk_empty, trk_adv;

  logic unused_bits;
  assign unused_bits = ^{io_i[3:2], io_i[0], sh_status[7:1]};

  assign accept   = (st_q == ST_IDLE) && start_i && (len_i != '0);
  assign gap_done = (st_q == ST_GAP) && (gap_q == GC_W'(GAP_CYC - 1));
  assign sh_load  = gap_done && (nxt_q != ST_DONE);
  assign q_start  = (st_q == ST_HDR) && sh_fin;
  assign trk_adv  = (st_q == ST_DATA) && q_fin;

  always_comb begin
    sh_vec   = '0;
    sh_nbits = '0;
    case (nxt_q)
      ST_WREN: begin
        sh_vec   = {OP_WREN, 32'h0};
        sh_nbits = HCNT_W'(8);
      end
      ST_RDSR: begin
        sh_vec   = {OP_RDSR, 32'h0};
        sh_nbits = HCNT_W'(16);
      end
      ST_HDR: begin
        if (a32_q) begin
          sh_vec   = {op_q, cur_addr};
          sh_nbits = HCNT_W'(40);
        end else begin
          sh_vec   = {op_q, cur_addr[23:0], 8'h0};
          sh_nbits = HCNT_W'(32);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      gap_q <= '0;
      op_q  <= '0;
      a32_q <= 1'b0;
      big_q <= 1'b0;
      nop_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          op_q  <= wr_op_i;
          a32_q <= addr32_i;
          big_q <= page_big_i;
          nop_q <= no_page_i;
          gap_q <= '0;
          nxt_q <= no_page_i ? ST_HDR : ST_WREN;
          st_q  <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_done) st_q <= nxt_q;
          else gap_q <= gap_q + GC_W'(1);
        end
        ST_WREN: if (sh_fin) begin
          gap_q <= '0;
          nxt_q <= ST_HDR;
          st_q  <= ST_GAP;
        end
        ST_HDR: if (sh_fin) st_q <= ST_DATA;
        ST_DATA: if (q_fin) begin
          if (nop_q) begin
            st_q <= ST_DONE;
          end else begin
            gap_q <= '0;
            nxt_q <= ST_RDSR;
            st_q  <= ST_GAP;
          end
        end
        ST_RDSR: if (sh_fin) begin
          if (!sh_status[0] && trk_empty) begin
            st_q <= ST_DONE;
          end else begin
            gap_q <= '0;
            nxt_q <= sh_status[0] ? ST_RDSR : ST_WREN;
            st_q  <= ST_GAP;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  qspi_pw_cmd_shift #(
    .VEC_W(HDR_W),
    .CNT_W(HCNT_W)
  ) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .vec_i   (sh_vec),
    .nbits_i (sh_nbits),
    .miso_i  (io_i[1]),
    .sck_o   (sh_sck),
    .mosi_o  (sh_mosi),
    .fin_o   (sh_fin),
    .status_o(sh_status)
  );

  qspi_pw_quad_tx #(
    .LEN_W(LEN_W)
  ) u_quad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(q_start),
    .count_i(chunk),
    .byte_i (wr_data_i),
    .valid_i(wr_valid_i),
    .ready_o(wr_ready_o),
    .sck_o  (q_sck),
    .nib_o  (q_nib),
    .fin_o  (q_fin)
  );

  qspi_pw_page_track #(
    .LEN_W (LEN_W),
    .PG_LG2(PG_LG2)
  ) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .big_i   (big_q),
    .nopage_i(nop_q),
    .adv_i   (trk_adv),
    .addr_o  (cur_addr),
    .chunk_o (chunk),
    .empty_o (trk_empty)
  );

  always_comb begin
    cs_no   = 1'b1;
    io_oe_o = 4'b0000;
    io_o    = {3'b000, sh_mosi};
    case (st_q)
      ST_WREN, ST_HDR, ST_RDSR: begin
        cs_no   = 1'b0;
        io_oe_o = 4'b0001;
      end
      ST_DATA: begin
        cs_no   = 1'b0;
        io_oe_o = 4'b1111;
        io_o    = q_nib;
      end
      default: ;
    endcase
  end

  assign sck_o  = (st_q == ST_DATA) ? q_sck : (sh_sck & ~cs_no);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/qspi_page_writer_chk.sv
module qspi_page_writer_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             sck_o,
  input logic             cs_no,
  input logic [3:0]       io_oe_o,
  input logic             wr_ready_o,
  input logic             busy_o,
  input logic             done_o
);
  p_cs_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!sck_o && io_oe_o == 4'b0000));

  p_cs_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);

  p_sck_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);

  p_oe_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'b0000 || io_oe_o == 4'b0001 || io_oe_o == 4'b1111));

  p_ready_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (io_oe_o == 4'b1111 && !sck_o && !cs_no));

  p_done_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));

  p_zero_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && len_i == '0) |=> !busy_o);
endmodule

bind qspi_page_writer qspi_page_writer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .len_i     (len_i),
  .sck_o     (sck_o),
  .cs_no     (cs_no),
  .io_oe_o   (io_oe_o),
  .wr_ready_o(wr_ready_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/qspi_page_writer_tb.sv
`timescale 1ns/1ps
module qspi_page_writer_tb;
  localparam int NPOLL = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic [7:0]  wr_op_i = '0;
  logic        addr32_i = 1'b0, page_big_i = 1'b0, no_page_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o, busy_o, done_o, sck_o, cs_no;
  logic [3:0]  io_o, io_oe_o, io_i;

  int total = 0, bad = 0;
  int poll_left = 0;
  bit nop_mode = 0;
  bit run_chk = 0;
  int done_seen = 0;

  int obs_b[$], obs_n[$], obs_s[$];
  int exp_b[$], exp_n[$], exp_s[$];

  always #10 clk = ~clk;

  assign io_i = {2'b00, (poll_left != 0), 1'b0};

  qspi_page_writer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .wr_op_i(wr_op_i), .addr32_i(addr32_i),
    .page_big_i(page_big_i), .no_page_i(no_page_i), .wr_data_i(wr_data_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .busy_o(busy_o),
    .done_o(done_o), .sck_o(sck_o), .cs_no(cs_no), .io_o(io_o),
    .io_oe_o(io_oe_o), .io_i(io_i)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int dbyte(int seed, int i);
    return (i * 13 + seed + (i >> 8)) & 255;
  endfunction

  // Bus monitor and device model
  bit mon_in = 0, mon_quad = 0;
  int mon_acc = 0, mon_nb = 0, mon_n = 0, mon_sb = 0, mon_start = 0;

  always @(negedge cs_no) begin
    mon_in = 1; mon_quad = 0; mon_acc = 0; mon_nb = 0;
    mon_n = 0; mon_sb = 0; mon_start = obs_b.size();
  end

  always @(posedge sck_o) begin
    if (!cs_no) begin
      if (io_oe_o == 4'hF) begin
        mon_acc = (mon_acc << 4) | int'(io_o);
        mon_nb += 4;
        mon_quad = 1;
      end else begin
        mon_acc = (mon_acc << 1) | int'(io_o[0]);
        mon_nb += 1;
        mon_sb += 1;
      end
      if (mon_nb == 8) begin
        obs_b.push_back(mon_acc & 255);
        mon_acc = 0; mon_nb = 0; mon_n++;
      end
    end
  end

  always @(posedge cs_no) begin
    if (mon_in) begin
      mon_in = 0;
      obs_n.push_back((mon_nb != 0) ? -1 : mon_n);
      obs_s.push_back(mon_sb / 8);
      if (mon_quad && !nop_mode) poll_left = NPOLL;
      else if (mon_n > 0 && obs_b[mon_start] == 5 && poll_left > 0) poll_left--;
    end
  end

  // Per-clock line checks
  always @(negedge clk) begin
    if (run_chk) begin
      if (done_o) done_seen++;
      chk(!cs_no || (!sck_o && io_oe_o == 4'h0), "R9 bus quiet with cs high",
          {sck_o, io_oe_o}, 0);
      chk(!wr_ready_o || (!sck_o && io_oe_o == 4'hF), "R12 ready only in stalled data phase",
          {sck_o, io_oe_o}, 15);
      chk(!done_o || cs_no, "R10 done with cs high", cs_no, 1);
    end
  end

  task automatic push_txn(int q[$], int nsingle);
    foreach (q[k]) exp_b.push_back(q[k]);
    exp_n.push_back(q.size());
    exp_s.push_back(nsingle);
  endtask

  task automatic build_exp(int addr, int len, int op, bit a32, bit big, bit nop, int seed);
    int off = 0;
    int a = addr;
    int page = big ? 512 : 256;
    while (off < len) begin
      int q[$];
      int chunk = nop ? len : ((len - off < page) ? len - off : page);
      int hb = a32 ? 5 : 4;
      if (!nop) begin
        q = {6};
        push_txn(q, 1);
      end
      q = {op};
      if (a32) q.push_back((a >> 24) & 255);
      q.push_back((a >> 16) & 255);
      q.push_back((a >> 8) & 255);
      q.push_back(a & 255);
      for (int i = 0; i < chunk; i++) q.push_back(dbyte(seed, off + i));
      push_txn(q, hb);
      if (!nop) begin
        for (int p = 0; p <= NPOLL; p++) begin
          q = {5, 0};
          push_txn(q, 2);
        end
      end
      off += chunk;
      a += page;
    end
  endtask

  task automatic compare(string tag);
    int ob = 0, eb = 0;
    chk(obs_n.size() == exp_n.size(), {tag, " transaction count"}, obs_n.size(), exp_n.size());
    for (int i = 0; i < exp_n.size() && i < obs_n.size(); i++) begin
      bit ok = (obs_n[i] == exp_n[i]) && (obs_s[i] == exp_s[i]);
      int fa = -1, fe = -1;
      if (ok) begin
        for (int j = 0; j < exp_n[i]; j++) begin
          if (obs_b[ob + j] != exp_b[eb + j] && ok) begin
            ok = 0; fa = obs_b[ob + j]; fe = exp_b[eb + j];
          end
        end
      end
      chk(ok, $sformatf("%s txn %0d len %0d/%0d single %0d/%0d byte", tag, i,
          obs_n[i], exp_n[i], obs_s[i], exp_s[i]), fa, fe);
      if (obs_n[i] > 0) ob += obs_n[i];
      eb += exp_n[i];
    end
  endtask

  task automatic feed(int n, int seed, bit stall);
    int idx = 0, cyc = 0;
    while (idx < n) begin
      @(negedge clk);
      cyc++;
      wr_valid_i = !(stall && (cyc % 3 == 1));
      wr_data_i  = 8'(dbyte(seed, idx));
      if (wr_valid_i && wr_ready_o) idx++;
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic run_case(string tag, int addr, int len, int op, bit a32, bit big,
                          bit nop, bit stall, bit poke, int seed);
    int t = 0;
    obs_b.delete(); obs_n.delete(); obs_s.delete();
    exp_b.delete(); exp_n.delete(); exp_s.delete();
    poll_left = 0; done_seen = 0; nop_mode = nop;
    build_exp(addr, len, op, a32, big, nop, seed);
    @(negedge clk);
    addr_i = 32'(addr); len_i = 16'(len); wr_op_i = 8'(op);
    addr32_i = a32; page_big_i = big; no_page_i = nop; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R10 busy after start"}, busy_o, 1);
    fork
      feed(len, seed, stall);
      begin
        if (poke) begin
          repeat (40) @(negedge clk);
          wr_op_i = 8'hAA; addr_i = 32'h0; len_i = 16'd3; no_page_i = 1'b1;
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
    join
    while (done_seen == 0 && t < 60000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    compare(tag);
    chk(done_seen == 1, {tag, " R10 single done pulse"}, done_seen, 1);
    chk(busy_o == 1'b0, {tag, " R10 idle after done"}, busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && sck_o == 1'b0, "R9 reset bus idle", {cs_no, sck_o}, 2);
    chk(busy_o == 1'b0 && done_o == 1'b0 && wr_ready_o == 1'b0,
        "R10 reset status", {busy_o, done_o, wr_ready_o}, 0);
    chk(io_oe_o == 4'h0, "R9 reset oe", io_oe_o, 0);
    rst_ni = 1'b1;
    run_chk = 1;

    run_case("R1 R2 R3 R4 R6 R7 p512 a24", 32'h003C00, 1100, 8'h32, 0, 1, 0, 0, 0, 1);
    run_case("R1 R4 R5 R6 R11 R12 p256 a32", 32'h12345600, 300, 8'hDE, 1, 0, 0, 1, 1, 7);
    run_case("R8 R5 R7 unpaged", 32'h003C00, 1300, 8'hDE, 0, 1, 1, 0, 0, 3);
    run_case("R1 R2 R3 one byte", 32'h00ABCDEF, 1, 8'h32, 1, 0, 0, 0, 0, 9);

    // R11: zero length start
    obs_n.delete();
    @(negedge clk);
    len_i = 16'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R11 zero length start ignored", busy_o, 0);
    repeat (20) @(negedge clk);
    chk(obs_n.size() == 0, "R11 zero length sends nothing", obs_n.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule